// File: doc/BRIEF.md
# Interrupt Source Mask and Pending Block

This block collects 64 level-sensitive interrupt request lines into a pending register. It screens them through a 64-bit mask register, in which a 1 disables the matching source. It reports whether any unmasked source is pending, and the number of the lowest-numbered one. Software reaches the block through a simple bus that carries both 32-bit word accesses and single-byte accesses.

The mask can be rewritten one 32-bit half at a time. It can also be edited with one-byte commands, which set or clear a single mask bit chosen by an index, or every mask bit at once. Any access the block does not support raises an error strobe and leaves all state untouched. Prioritisation beyond "lowest index wins", vector generation and acknowledge cycles belong to the logic that consumes the outputs.

Top module: `irq_mask_ctl`

## Requirements
- R1: After reset the mask reads as all ones, `irq_active` is 0, `irq_src` is 0 and `bus_err` is 0.
- R2: A word write (`bus_word`=1) at offset 0x0C loads `bus_wdata` into mask bits [31:0] and leaves bits [63:32] unchanged.
- R3: A word write at offset 0x08 loads `bus_wdata` into mask bits [63:32] and leaves bits [31:0] unchanged.
- R4: A byte write (`bus_word`=0) at offset 0x1C with `bus_wdata[6]`=0 sets the mask bit numbered by `bus_wdata[5:0]` and leaves every other mask bit unchanged.
- R5: A byte write at offset 0x1C with `bus_wdata[6]`=1 sets all 64 mask bits, whatever bits [5:0] hold.
- R6: A byte write at offset 0x1D with `bus_wdata[6]`=0 clears the mask bit numbered by `bus_wdata[5:0]` and leaves every other mask bit unchanged.
- R7: A byte write at offset 0x1D with `bus_wdata[6]`=1 clears all 64 mask bits.
- R8: Any write that is not a word write to 0x08 or 0x0C, and not a byte write to 0x1C or 0x1D, pulses `bus_err` for one cycle after the write. It changes neither the mask nor the pending register.
- R9: A word read returns, one cycle later on `bus_rdata`, pending bits [63:32] at 0x00, pending bits [31:0] at 0x04, mask bits [63:32] at 0x08 and mask bits [31:0] at 0x0C. Any other read returns 0 and pulses `bus_err`.
- R10: The pending register captures `irq_req` on every clock edge and cannot be written from the bus.
- R11: `irq_active` is 1 exactly when some bit of (pending AND NOT mask) is 1. `irq_src` then gives the lowest such bit number, and is 0 when none is set.
- R12: A mask change made by a write is not yet visible on `irq_active`/`irq_src` in the cycle after the write; it appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; byte commands use bits [7:0] |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse for an unsupported access |
| irq_req | input | 64 | Level-sensitive request lines |
| irq_active | output | 1 | Some unmasked source is pending |
| irq_src | output | 6 | Lowest unmasked pending source number |

## Verification
The bench targets the index boundaries 0 and 63. A design that sliced the command index wrongly would touch the wrong bit or the wrong half. It checks that bit 6 overrides the index: a design that ignored it would change one bit where it should change all. It checks that word writes to one half preserve the other half, which a full-width assignment would zero. It sends byte accesses to word offsets and word accesses to command offsets. A loose decoder would accept these as valid, and the mask read-back would then differ. It also checks the cycle in which a mask change reaches the outputs, which a combinational output path would show one cycle early.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PEND_HI,
    RD_PEND_LO,
    RD_MASK_HI,
    RD_MASK_LO
  } rd_sel_e;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic set_cmd;
    logic clr_cmd;
  } mask_op_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_mask_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int OFF_PEND_HI = 8'h00,
  parameter int OFF_PEND_LO = 8'h04,
  parameter int OFF_MASK_HI = 8'h08,
  parameter int OFF_MASK_LO = 8'h0C,
  parameter int OFF_SET     = 8'h1C,
  parameter int OFF_CLR     = 8'h1D
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mask_op_t          op_o,
  output rd_sel_e           rd_sel_o,
  output logic              err_o
);

  logic wr_ok;
  logic rd_err;

  always_comb begin
    op_o.wr_hi   = wr_i &&  word_i && (addr_i == ADDR_W'(OFF_MASK_HI));
    op_o.wr_lo   = wr_i &&  word_i && (addr_i == ADDR_W'(OFF_MASK_LO));
    op_o.set_cmd = wr_i && !word_i && (addr_i == ADDR_W'(OFF_SET));
    op_o.clr_cmd = wr_i && !word_i && (addr_i == ADDR_W'(OFF_CLR));
    wr_ok = op_o.wr_hi | op_o.wr_lo | op_o.set_cmd | op_o.clr_cmd;

    rd_sel_o = RD_NONE;
    if (rd_i && word_i) begin
      if      (addr_i == ADDR_W'(OFF_PEND_HI)) rd_sel_o = RD_PEND_HI;
      else if (addr_i == ADDR_W'(OFF_PEND_LO)) rd_sel_o = RD_PEND_LO;
      else if (addr_i == ADDR_W'(OFF_MASK_HI)) rd_sel_o = RD_MASK_HI;
      else if (addr_i == ADDR_W'(OFF_MASK_LO)) rd_sel_o = RD_MASK_LO;
    end
    rd_err = rd_i && (rd_sel_o == RD_NONE);
    err_o  = (wr_i && !wr_ok) || rd_err;
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_mask_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  mask_op_t          op_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [NSRC-1:0]   mask_o
);

  localparam int IDX_W   = $clog2(NSRC);
  localparam int ALL_BIT = IDX_W;

  logic [IDX_W-1:0] cmd_idx;
  logic             cmd_all;
  logic [NSRC-1:0]  cmd_bit;
  logic [NSRC-1:0]  mask_q;

  assign cmd_idx = wdata_i[IDX_W-1:0];
  assign cmd_all = wdata_i[ALL_BIT];
  assign cmd_bit = {{(NSRC-1){1'b0}}, 1'b1} << cmd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (op_i.set_cmd) begin
      if (cmd_all) mask_q <= '1;
      else         mask_q <= mask_q | cmd_bit;
    end else if (op_i.clr_cmd) begin
      if (cmd_all) mask_q <= '0;
      else         mask_q <= mask_q & ~cmd_bit;
    end else begin
      if (op_i.wr_hi) mask_q[NSRC-1:WORD_W] <= wdata_i;
      if (op_i.wr_lo) mask_q[WORD_W-1:0]    <= wdata_i;
    end
  end

  assign mask_o = mask_q;

  logic arm_q;
  always_ff @(posedge clk) arm_q <= !rst;

  p_lo_write_r2: assert property (@(posedge clk) disable iff (rst || !arm_q)
    $past(op_i.wr_lo) |-> (mask_q[WORD_W-1:0] == $past(wdata_i)) &&
                          (mask_q[NSRC-1:WORD_W] == $past(mask_q[NSRC-1:WORD_W])));
  p_hi_write_r3: assert property (@(posedge clk) disable iff (rst || !arm_q)
    $past(op_i.wr_hi) |-> (mask_q[NSRC-1:WORD_W] == $past(wdata_i)) &&
                          (mask_q[WORD_W-1:0] == $past(mask_q[WORD_W-1:0])));
  p_set_one_r4: assert property (@(posedge clk) disable iff (rst || !arm_q)
    ($past(op_i.set_cmd) && !$past(cmd_all)) |-> mask_q == ($past(mask_q) | $past(cmd_bit)));
  p_set_all_r5: assert property (@(posedge clk) disable iff (rst || !arm_q)
    ($past(op_i.set_cmd) && $past(cmd_all)) |-> (&mask_q));
  p_clr_one_r6: assert property (@(posedge clk) disable iff (rst || !arm_q)
    ($past(op_i.clr_cmd) && !$past(cmd_all)) |-> mask_q == ($past(mask_q) & ~$past(cmd_bit)));
  p_clr_all_r7: assert property (@(posedge clk) disable iff (rst || !arm_q)
    ($past(op_i.clr_cmd) && $past(cmd_all)) |-> (mask_q == '0));

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= req_i;
  end

  assign pend_o = pend_q;

  logic arm_q;
  always_ff @(posedge clk) arm_q <= !rst;

  p_pend_follow_r10: assert property (@(posedge clk) disable iff (rst || !arm_q)
    pend_q == $past(req_i));

endmodule

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
  parameter int NSRC = 64
) (
  input  logic [NSRC-1:0]         vec_i,
  output logic                    any_o,
  output logic [$clog2(NSRC)-1:0] idx_o
);

  localparam int IDX_W = $clog2(NSRC);

  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irq_mask_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [NSRC-1:0]   irq_req,
  output logic              irq_active,
  output logic [IDX_W-1:0]  irq_src
);

  mask_op_t        op;
  rd_sel_e         rd_sel;
  logic            acc_err;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] hit_vec;
  logic            hit_any;
  logic [IDX_W-1:0] hit_idx;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i(bus_wr), .rd_i(bus_rd), .word_i(bus_word), .addr_i(bus_addr),
    .op_o(op), .rd_sel_o(rd_sel), .err_o(acc_err)
  );

  irq_mask_reg #(.NSRC(NSRC), .WORD_W(WORD_W)) u_mask (
    .clk(clk), .rst(rst), .op_i(op), .wdata_i(bus_wdata), .mask_o(mask_q)
  );

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req_i(irq_req), .pend_o(pend_q)
  );

  assign hit_vec = pend_q & ~mask_q;

  irq_lowest_find #(.NSRC(NSRC)) u_find (
    .vec_i(hit_vec), .any_o(hit_any), .idx_o(hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
      irq_active <= 1'b0;
      irq_src    <= '0;
    end else begin
      bus_err    <= acc_err;
      irq_active <= hit_any;
      irq_src    <= hit_idx;
      unique case (rd_sel)
        RD_PEND_HI: bus_rdata <= pend_q[NSRC-1:WORD_W];
        RD_PEND_LO: bus_rdata <= pend_q[WORD_W-1:0];
        RD_MASK_HI: bus_rdata <= mask_q[NSRC-1:WORD_W];
        RD_MASK_LO: bus_rdata <= mask_q[WORD_W-1:0];
        default:    bus_rdata <= '0;
      endcase
    end
  end

  logic arm_q;
  always_ff @(posedge clk) arm_q <= !rst;

  p_err_keeps_mask_r8: assert property (@(posedge clk) disable iff (rst || !arm_q)
    bus_err |-> $stable(mask_q));
  p_active_tracks_r11: assert property (@(posedge clk) disable iff (rst || !arm_q)
    irq_active == (|$past(hit_vec)));
  p_src_idle_zero_r11: assert property (@(posedge clk) disable iff (rst || !arm_q)
    !irq_active |-> (irq_src == '0));
  p_active_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_active && !bus_err));

endmodule

// File: tb/test_irq_mask_ctl.sv
module test_irq_mask_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [63:0] irq_req = '0;
  logic        irq_active;
  logic [5:0]  irq_src;

  always #5 clk = ~clk;

  irq_mask_ctl i_irq_mask_ctl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_req(irq_req), .irq_active(irq_active), .irq_src(irq_src)
  );

  typedef struct {
    int          due;
    int          kind;   // 0 rdata, 1 err, 2 active, 3 src
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          n_run = 0, n_fail = 0;
  logic [63:0] mdl_mask = '1;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item falling due in this cycle
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        logic [31:0] act;
        case (sb_q[i].kind)
          0:       act = bus_rdata;
          1:       act = {31'd0, bus_err};
          2:       act = {31'd0, irq_active};
          default: act = {26'd0, irq_src};
        endcase
        n_run++;
        if (act !== sb_q[i].exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h cycle=%0d",
                   sb_q[i].tag, sb_q[i].kind, act, sb_q[i].exp, cyc);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic push(int due, int kind, logic [31:0] exp, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [6:0] ref_lowest(logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return {1'b1, 6'(i)};
    return 7'd0;
  endfunction

  task automatic expect_outs(string tag);
    logic [6:0] r;
    r = ref_lowest(irq_req & ~mdl_mask);
    push(cyc, 2, {31'd0, r[6]}, tag);
    push(cyc, 3, {26'd0, r[5:0]}, tag);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d, logic word, string tag);
    logic ok;
    ok = 1'b1;
    if (word && a == 8'h0C)       mdl_mask[31:0]  = d;
    else if (word && a == 8'h08)  mdl_mask[63:32] = d;
    else if (!word && a == 8'h1C) begin
      if (d[6]) mdl_mask = '1; else mdl_mask[d[5:0]] = 1'b1;
    end else if (!word && a == 8'h1D) begin
      if (d[6]) mdl_mask = '0; else mdl_mask[d[5:0]] = 1'b0;
    end else ok = 1'b0;
    push(cyc + 1, 1, {31'd0, !ok}, tag);
    bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_word = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [7:0] a, string tag);
    logic [31:0] e;
    logic        bad;
    bad = 1'b0;
    case (a)
      8'h00:   e = irq_req[63:32];
      8'h04:   e = irq_req[31:0];
      8'h08:   e = mdl_mask[63:32];
      8'h0C:   e = mdl_mask[31:0];
      default: begin e = '0; bad = 1'b1; end
    endcase
    push(cyc + 1, 0, e, tag);
    push(cyc + 1, 1, {31'd0, bad}, tag);
    bus_rd = 1'b1; bus_word = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_word = 1'b0; bus_addr = '0;
  endtask

  task automatic set_req(logic [63:0] v);
    irq_req = v;
    idle(2);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] old_r;
    idle(3);
    rst = 1'b0;
    // R1: reset state
    push(cyc, 2, 32'd0, "R1"); push(cyc, 3, 32'd0, "R1"); push(cyc, 1, 32'd0, "R1");
    bus_read(8'h08, "R1"); bus_read(8'h0C, "R1");

    // R11: everything masked, nothing active
    set_req(64'h0000_0100_0000_0020);
    expect_outs("R11");

    // R2: low half write keeps high half
    bus_write(8'h0C, 32'h0000_00F0, 1'b1, "R2");
    idle(1); expect_outs("R2");
    bus_read(8'h0C, "R2"); bus_read(8'h08, "R2");

    // R6: clear single bit 40 unmasks source 40
    bus_write(8'h1D, 32'h0000_0028, 1'b0, "R6");
    idle(1); expect_outs("R6");
    bus_read(8'h08, "R6");

    // R12: old mask still visible one cycle after write, new one after two
    old_r = ref_lowest(irq_req & ~mdl_mask);
    bus_write(8'h0C, 32'h0000_0000, 1'b1, "R12");
    push(cyc, 3, {26'd0, old_r[5:0]}, "R12");
    idle(1); expect_outs("R12");

    // R4: set single bit 5 (bit 7 set, bit 6 clear)
    bus_write(8'h1C, 32'h0000_0085, 1'b0, "R4");
    idle(1); expect_outs("R4");
    bus_read(8'h0C, "R4"); bus_read(8'h08, "R4");

    // R3: high half write keeps low half
    bus_write(8'h08, 32'h1234_5678, 1'b1, "R3");
    idle(1); expect_outs("R3");
    bus_read(8'h08, "R3"); bus_read(8'h0C, "R3");

    // R5: set all, index bits ignored
    bus_write(8'h1C, 32'h0000_0043, 1'b0, "R5");
    idle(1); expect_outs("R5");
    bus_read(8'h08, "R5"); bus_read(8'h0C, "R5");

    // R7: clear all
    bus_write(8'h1D, 32'h0000_0045, 1'b0, "R7");
    set_req(64'h8000_0000_0000_0001);
    expect_outs("R7");
    bus_read(8'h08, "R7"); bus_read(8'h0C, "R7");

    // R4/R11: index 0 masked leaves 63 as lowest
    bus_write(8'h1C, 32'h0000_0000, 1'b0, "R4");
    idle(1); expect_outs("R11");
    // R4/R6: index 63 boundary
    bus_write(8'h1C, 32'h0000_003F, 1'b0, "R4");
    idle(1); expect_outs("R4");
    bus_read(8'h08, "R4");
    bus_write(8'h1D, 32'h0000_003F, 1'b0, "R6");
    idle(1); expect_outs("R6");

    // R8: unsupported writes flag and change nothing
    bus_write(8'h10, 32'hFFFF_FFFF, 1'b1, "R8");
    bus_write(8'h0C, 32'hFFFF_FFFF, 1'b0, "R8");
    bus_write(8'h1C, 32'h0000_0040, 1'b1, "R8");
    bus_write(8'h1D, 32'h0000_0040, 1'b1, "R8");
    bus_write(8'h04, 32'h0000_0000, 1'b1, "R8");
    idle(1); expect_outs("R8");
    bus_read(8'h08, "R8"); bus_read(8'h0C, "R8"); bus_read(8'h04, "R8");

    // R9/R10: pending read-back and bad read
    set_req(64'hA5A5_0F0F_3C3C_8001);
    bus_read(8'h00, "R10"); bus_read(8'h04, "R10");
    bus_read(8'h14, "R9"); bus_read(8'h1C, "R9");
    expect_outs("R11");

    // R11: only source 63 unmasked
    bus_write(8'h1C, 32'h0000_0040, 1'b0, "R5");
    bus_write(8'h1D, 32'h0000_003F, 1'b0, "R6");
    idle(1); expect_outs("R11");
    set_req(64'h0);
    expect_outs("R11");

    idle(3);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard left=%0d expected=0", sb_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule